// File: doc/BRIEF.md
# Capability PTE Permission Checker

This block sits beside the result path of an RV64 page-table walker. For each translated access it looks at two capability bits of the leaf page-table entry: a capability-write permission bit (`pte_capw`) and a capability-read generation bit (`pte_gen`). It also looks at the kind of access, whether the access moves a capability, and the tag of a capability being stored. From these it decides whether the access needs a store page fault, whether a loaded capability must lose its tag, or whether the walker must write the entry back with new bit values.

A status-register generation bit and a mode input also feed the decision. The mode input selects whether accessed/dirty handling is done by software or by hardware. When a tagged capability is stored to a page in the pre-write state, this mode decides between trapping to software and requesting a hardware write-back. The write-back raises the write permission and copies the status generation bit into the entry.

Results appear one cycle after a request strobe, together with a response valid. Translation modes without spare entry bits bypass the checker. A build-time option makes the checker fault more often: every capability store to a page with neither bit set then faults, whatever the tag.

Top module: `cap_pte_guard`

## Requirements
- R1: With `pte_capw`=0 and `pte_gen`=0, a store (`acc_kind`=01) or AMO (`acc_kind`=10) that moves a capability with `st_tag`=1 sets `st_fault`.
- R2: With `pte_capw`=0, a load (`acc_kind`=00) or AMO that moves a capability sets `ld_tag_clr`.
- R3: With `pte_capw`=0, `pte_gen`=1 and `hw_ad_mode`=0, a tagged capability store or AMO sets `st_fault` and not `upd_req`.
- R4: With `pte_capw`=0, `pte_gen`=1 and `hw_ad_mode`=1, a tagged capability store or AMO leaves `st_fault` low and sets `upd_req`, with `upd_capw`=1 and `upd_gen` equal to `stat_gen`.
- R5: With `pte_capw`=1, every access completes with `st_fault`, `ld_tag_clr` and `upd_req` all low.
- R6: The checker is active only for `xlat_mode` codes 8, 9 and 10. For any other code, all result outputs stay low.
- R7: With parameter `CONSERVATIVE_ST`=1, a capability store to a page with both bits clear faults even when `st_tag`=0. Stores that do not move a capability are unaffected.
- R8: With `CONSERVATIVE_ST`=0, untagged capability stores and stores that do not move a capability complete to a `pte_capw`=0 page with no fault and no update.
- R9: Results are registered. For a request strobed with `req_vld` in one cycle, `rsp_vld` and the results appear after the next rising edge. In cycles with no response, and during reset, every output is low.
- R10: `st_fault` and `upd_req` are never high in the same cycle.
- R11: Loads and the unused access code (`acc_kind`=11) never raise `st_fault` or `upd_req`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_vld | input | 1 | Access request strobe |
| xlat_mode | input | 4 | Translation mode code; 8, 9, 10 enable the checker |
| pte_capw | input | 1 | Entry capability-write permission bit |
| pte_gen | input | 1 | Entry capability-read generation bit |
| acc_kind | input | 2 | 00 load, 01 store, 10 AMO, 11 unused |
| acc_cap | input | 1 | Access moves a capability |
| st_tag | input | 1 | Tag of the capability being stored |
| stat_gen | input | 1 | Status-register generation bit of current privilege |
| hw_ad_mode | input | 1 | 1 = hardware accessed/dirty updates, 0 = software |
| rsp_vld | output | 1 | Response valid, one cycle after `req_vld` |
| st_fault | output | 1 | Store page fault request |
| ld_tag_clr | output | 1 | Clear tag of the loaded capability |
| upd_req | output | 1 | Entry write-back request |
| upd_capw | output | 1 | New write-permission value for write-back |
| upd_gen | output | 1 | New generation value for write-back |

## Verification
Every result of this block is due exactly one rising edge after the request that produced it, and it is held for only that one cycle. The bench drives each request on a falling edge and samples the complete response on the next falling edge. That sample falls after the single register stage and before any later request can disturb the outputs. The bench also samples in the following idle cycle to confirm the outputs have dropped. In the back-to-back case, each response is sampled on the falling edge at which the next request is driven.

// File: rtl/cpg_pkg.sv
package cpg_pkg;
    localparam int MODE_W = 4;
    localparam int N_MODES = 3;
    localparam logic [MODE_W-1:0] MODE_LIST [N_MODES] = '{4'd8, 4'd9, 4'd10};

    typedef enum logic [1:0] {
        ACC_LOAD  = 2'b00,
        ACC_STORE = 2'b01,
        ACC_AMO   = 2'b10,
        ACC_NONE  = 2'b11
    } acc_e;

    typedef struct packed {
        logic vld;
        logic st_fault;
        logic tag_clr;
        logic upd_req;
        logic upd_capw;
        logic upd_gen;
    } rsp_t;
endpackage

// File: rtl/cpg_mode_gate.sv
module cpg_mode_gate
    import cpg_pkg::*;
(
    input  logic [MODE_W-1:0] mode,
    output logic              mode_ok
);
    logic [N_MODES-1:0] hit;

    generate
        for (genvar i = 0; i < N_MODES; i++) begin : g_cmp
            assign hit[i] = (mode == MODE_LIST[i]);
        end
    endgenerate

    assign mode_ok = |hit;
endmodule

// File: rtl/cpg_store_rule.sv
module cpg_store_rule #(
    parameter bit CONSERVATIVE = 1'b0
) (
    input  logic active,
    input  logic is_store,
    input  logic moves_cap,
    input  logic capw,
    input  logic gen,
    input  logic tag,
    input  logic stat_gen,
    input  logic hw_ad,
    output logic fault,
    output logic upd,
    output logic upd_gen
);
    logic cap_st;
    logic nocap_state;
    logic pre_state;
    logic nocap_trig;

    generate
        if (CONSERVATIVE) begin : g_cons
            assign nocap_trig = 1'b1;
        end else begin : g_exact
            assign nocap_trig = tag;
        end
    endgenerate

    always_comb begin
        cap_st      = active && is_store && moves_cap;
        nocap_state = !capw && !gen;
        pre_state   = !capw && gen;
        fault       = cap_st && ((nocap_state && nocap_trig) ||
                                 (pre_state && tag && !hw_ad));
        upd         = cap_st && pre_state && tag && hw_ad;
        upd_gen     = upd && stat_gen;
    end
endmodule

// File: rtl/cpg_load_rule.sv
module cpg_load_rule (
    input  logic active,
    input  logic is_read,
    input  logic moves_cap,
    input  logic capw,
    output logic tag_clr
);
    assign tag_clr = active && is_read && moves_cap && !capw;
endmodule

// File: rtl/cap_pte_guard.sv
module cap_pte_guard
    import cpg_pkg::*;
#(
    parameter bit CONSERVATIVE_ST = 1'b0
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_vld,
    input  logic [MODE_W-1:0] xlat_mode,
    input  logic              pte_capw,
    input  logic              pte_gen,
    input  logic [1:0]        acc_kind,
    input  logic              acc_cap,
    input  logic              st_tag,
    input  logic              stat_gen,
    input  logic              hw_ad_mode,
    output logic              rsp_vld,
    output logic              st_fault,
    output logic              ld_tag_clr,
    output logic              upd_req,
    output logic              upd_capw,
    output logic              upd_gen
);
    acc_e kind;
    logic mode_ok;
    logic is_store;
    logic is_read;
    logic fault_c;
    logic upd_c;
    logic upd_gen_c;
    logic clr_c;
    rsp_t rsp_d;
    rsp_t rsp_q;

    assign kind     = acc_e'(acc_kind);
    assign is_store = (kind == ACC_STORE) || (kind == ACC_AMO);
    assign is_read  = (kind == ACC_LOAD)  || (kind == ACC_AMO);

    cpg_mode_gate u_gate (
        .mode    (xlat_mode),
        .mode_ok (mode_ok)
    );

    cpg_store_rule #(.CONSERVATIVE(CONSERVATIVE_ST)) u_store (
        .active    (mode_ok),
        .is_store  (is_store),
        .moves_cap (acc_cap),
        .capw      (pte_capw),
        .gen       (pte_gen),
        .tag       (st_tag),
        .stat_gen  (stat_gen),
        .hw_ad     (hw_ad_mode),
        .fault     (fault_c),
        .upd       (upd_c),
        .upd_gen   (upd_gen_c)
    );

    cpg_load_rule u_load (
        .active    (mode_ok),
        .is_read   (is_read),
        .moves_cap (acc_cap),
        .capw      (pte_capw),
        .tag_clr   (clr_c)
    );

    always_comb begin
        rsp_d = '0;
        if (req_vld) begin
            rsp_d.vld      = 1'b1;
            rsp_d.st_fault = fault_c;
            rsp_d.tag_clr  = clr_c;
            rsp_d.upd_req  = upd_c;
            rsp_d.upd_capw = upd_c;
            rsp_d.upd_gen  = upd_gen_c;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) rsp_q <= '0;
        else        rsp_q <= rsp_d;
    end

    assign rsp_vld    = rsp_q.vld;
    assign st_fault   = rsp_q.st_fault;
    assign ld_tag_clr = rsp_q.tag_clr;
    assign upd_req    = rsp_q.upd_req;
    assign upd_capw   = rsp_q.upd_capw;
    assign upd_gen    = rsp_q.upd_gen;

    // R10
    excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({st_fault, upd_req}));

    // R9
    rsp_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        req_vld |=> rsp_vld);

    // R9
    rsp_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !req_vld |=> !rsp_vld);

    // R9
    quiet_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_vld |-> !(st_fault || ld_tag_clr || upd_req || upd_capw || upd_gen));

    // R11
    load_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && (acc_kind == 2'b00 || acc_kind == 2'b11)) |=> !st_fault && !upd_req);

    // R6
    bypass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && !mode_ok) |=> !st_fault && !ld_tag_clr && !upd_req);

    // R5
    capw_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && pte_capw) |=> !st_fault && !ld_tag_clr && !upd_req);

    // R4
    hw_upd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_vld && mode_ok && is_store && acc_cap && st_tag && !pte_capw && pte_gen && hw_ad_mode)
        |=> upd_req && upd_capw && !st_fault && (upd_gen == $past(stat_gen)));
endmodule

// File: tb/test_cap_pte_guard.sv
`timescale 1ns/1ps
module test_cap_pte_guard;
    typedef struct packed {
        logic [3:0] mode;
        logic       capw;
        logic       gen;
        logic [1:0] kind;
        logic       cap;
        logic       tag;
        logic       sgen;
        logic       hw;
        logic       e_f;
        logic       e_c;
        logic       e_u;
        logic       e_ucw;
        logic       e_ug;
        logic [7:0] rq;
    } vec_t;

    localparam int NV = 16;
    // fields: mode capw gen kind cap tag sgen hw | fault clr upd ucapw ugen | req
    localparam vec_t TBL [NV] = '{
        '{4'd8,  1'b0, 1'b0, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd1},  // R1 store
        '{4'd9,  1'b0, 1'b0, 2'b10, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 8'd1},  // R1 AMO
        '{4'd10, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 load
        '{4'd8,  1'b0, 1'b1, 2'b00, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 8'd2},  // R2 pre-state load
        '{4'd8,  1'b0, 1'b1, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 8'd3},  // R3
        '{4'd8,  1'b0, 1'b1, 2'b01, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1, 8'd4},  // R4 gen 1
        '{4'd9,  1'b0, 1'b1, 2'b01, 1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 8'd4},  // R4 gen 0
        '{4'd8,  1'b1, 1'b0, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd5},  // R5 store
        '{4'd8,  1'b1, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd5},  // R5 load
        '{4'd0,  1'b0, 1'b0, 2'b01, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd6},  // R6 bare
        '{4'd11, 1'b0, 1'b0, 2'b00, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd6},  // R6 other code
        '{4'd8,  1'b0, 1'b0, 2'b01, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd8},  // R8 untagged
        '{4'd8,  1'b0, 1'b0, 2'b01, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd8},  // R8 plain store
        '{4'd8,  1'b0, 1'b1, 2'b01, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd8},  // R8 pre-state untagged
        '{4'd8,  1'b0, 1'b0, 2'b00, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd11}, // R11 plain load
        '{4'd8,  1'b0, 1'b0, 2'b11, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 8'd11}  // R11 unused code
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_vld = 1'b0;
    logic [3:0] xlat_mode = '0;
    logic pte_capw = 1'b0, pte_gen = 1'b0, acc_cap = 1'b0, st_tag = 1'b0;
    logic stat_gen = 1'b0, hw_ad_mode = 1'b0;
    logic [1:0] acc_kind = 2'b11;
    logic rsp_vld, st_fault, ld_tag_clr, upd_req, upd_capw, upd_gen;
    logic c_vld, c_fault, c_clr, c_upd, c_ucw, c_ug;
    int checks = 0;
    int fails = 0;
    logic both_seen = 1'b0;

    always #2.5 clk = ~clk;

    cap_pte_guard i_cap_pte_guard (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .xlat_mode(xlat_mode),
        .pte_capw(pte_capw), .pte_gen(pte_gen), .acc_kind(acc_kind), .acc_cap(acc_cap),
        .st_tag(st_tag), .stat_gen(stat_gen), .hw_ad_mode(hw_ad_mode),
        .rsp_vld(rsp_vld), .st_fault(st_fault), .ld_tag_clr(ld_tag_clr),
        .upd_req(upd_req), .upd_capw(upd_capw), .upd_gen(upd_gen)
    );

    cap_pte_guard #(.CONSERVATIVE_ST(1'b1)) i_cap_pte_guard_cons (
        .clk(clk), .rst_n(rst_n), .req_vld(req_vld), .xlat_mode(xlat_mode),
        .pte_capw(pte_capw), .pte_gen(pte_gen), .acc_kind(acc_kind), .acc_cap(acc_cap),
        .st_tag(st_tag), .stat_gen(stat_gen), .hw_ad_mode(hw_ad_mode),
        .rsp_vld(c_vld), .st_fault(c_fault), .ld_tag_clr(c_clr),
        .upd_req(c_upd), .upd_capw(c_ucw), .upd_gen(c_ug)
    );

    task automatic chk(input string rq, input logic [5:0] act, input logic [5:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s act=%b exp=%b", rq, act, exp);
        end
    endtask

    task automatic drive(input vec_t v);
        req_vld    = 1'b1;
        xlat_mode  = v.mode;
        pte_capw   = v.capw;
        pte_gen    = v.gen;
        acc_kind   = v.kind;
        acc_cap    = v.cap;
        st_tag     = v.tag;
        stat_gen   = v.sgen;
        hw_ad_mode = v.hw;
    endtask

    function automatic logic [5:0] main_rsp();
        return {rsp_vld, st_fault, ld_tag_clr, upd_req, upd_capw, upd_gen};
    endfunction

    function automatic logic [5:0] cons_rsp();
        return {c_vld, c_fault, c_clr, c_upd, c_ucw, c_ug};
    endfunction

    function automatic logic [5:0] exp_of(input vec_t v);
        return {1'b1, v.e_f, v.e_c, v.e_u, v.e_ucw, v.e_ug};
    endfunction

    initial begin
        repeat (5000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        // R9 reset state
        repeat (3) @(negedge clk);
        chk("R9 reset", main_rsp(), 6'b0);
        rst_n = 1'b1;

        foreach (TBL[i]) begin
            @(negedge clk);
            drive(TBL[i]);
            @(negedge clk);
            chk($sformatf("R%0d vec%0d", TBL[i].rq, i), main_rsp(), exp_of(TBL[i]));
            if (st_fault && upd_req) both_seen = 1'b1;
            req_vld = 1'b0;
        end

        // R10 exclusivity over the table
        checks++;
        if (both_seen) begin
            fails++;
            $display("FAIL R10 act=1 exp=0");
        end

        // R9 idle cycle returns outputs low
        @(negedge clk);
        chk("R9 idle", main_rsp(), 6'b0);

        // R9 back-to-back: fault response then update response
        @(negedge clk);
        drive(TBL[0]);
        @(negedge clk);
        chk("R9 b2b first", main_rsp(), exp_of(TBL[0]));
        drive(TBL[5]);
        @(negedge clk);
        chk("R9 b2b second", main_rsp(), exp_of(TBL[5]));
        req_vld = 1'b0;
        @(negedge clk);
        chk("R9 b2b drain", main_rsp(), 6'b0);

        // R7 conservative option: untagged capability store to no-cap page faults
        drive(TBL[11]);
        @(negedge clk);
        chk("R7 cons untagged", cons_rsp(), 6'b110000);
        chk("R8 default untagged", main_rsp(), 6'b100000);
        // R7 plain store unaffected by the option
        drive(TBL[12]);
        @(negedge clk);
        chk("R7 cons plain", cons_rsp(), 6'b100000);
        // R7 pre-state untagged store unaffected by the option
        drive(TBL[13]);
        @(negedge clk);
        chk("R7 cons pre-state", cons_rsp(), 6'b100000);
        req_vld = 1'b0;

        // R9 reset mid-stream clears a pending response
        @(negedge clk);
        drive(TBL[0]);
        rst_n = 1'b0;
        @(negedge clk);
        chk("R9 reset hold", main_rsp(), 6'b0);
        req_vld = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule